// File: doc/BRIEF.md
# Dual-Bank Concurrent Access Arbiter

The arbiter sits between a host bus and a flash array split into two banks. For every host read it picks the bank that the address points to, raises that bank's read enable and tells the output multiplexer whether to pass array data or status bits. The data path is true array data when the addressed bank is idle and status when it is busy. One bank can therefore be read at full speed while the other bank is programming or erasing.

For every host write command (word program, sector erase, block erase or chip erase) the arbiter decides whether the command may start. A command starts only when neither bank is busy and no start is still in flight. Otherwise it is dropped and a reject flag is raised. This rule means the two banks are never written at the same time. A chip erase starts on its own line and counts as a write to both banks for as long as it runs.

The bank is chosen by one high-order address bit, and its position is a parameter. The busy status of each bank, and a separate chip-erase busy flag, come from the command engine. All request outputs are registered and appear one clock after the request.

Top module: `dual_bank_arbiter`

## Requirements
- R1: A read request with chip enable and output enable both low, addressed to a bank that is not busy, raises that bank's bit of `rd_en_o` and drives `rd_status_o` low in the cycle after the request.
- R2: A read addressed to a bank whose `bank_busy_i` bit is high gives `rd_status_o` = 1, which selects status instead of array data, together with that bank's `rd_en_o` bit.
- R3: Address bit `BANK_BIT` selects the bank: 0 selects bank 0 (`rd_en_o[0]`, `wr_start_o[0]`) and 1 selects bank 1.
- R4: A write with `wr_kind_i` of 0 (program), 1 (sector erase) or 2 (block erase) is accepted when no bank is busy. It then pulses the addressed bank's bit of `wr_start_o` for one cycle. Kind 3 (chip erase) pulses `wr_chip_o` instead and leaves `wr_start_o` at 0.
- R5: A write requested while any `bank_busy_i` bit or `chip_busy_i` is high raises `reject_o` for one cycle and starts nothing. `wr_start_o` never has more than one bit set, and it is never high in the same cycle as `reject_o`.
- R6: A start that was just issued counts as busy. A write requested in the cycle in which `wr_start_o` or `wr_chip_o` is high is rejected.
- R7: While `chip_busy_i` is high, or while `wr_chip_o` is high, a read of either bank returns status.
- R8: When a read and an accepted write arrive in the same cycle, a read of the other bank returns array data. A read of the same bank, or any read alongside a chip erase, returns status.
- R9: While `ce_ni` is high, read and write requests are ignored: `rd_en_o`, `wr_start_o`, `wr_chip_o` and `reject_o` all stay 0. While `oe_ni` is high, reads are suppressed but writes still work.
- R10: `bus_oe_o` is high exactly when `ce_ni` and `oe_ni` are both low, with no clock delay.
- R11: While `rst_ni` is low, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| rd_req_i | input | 1 | Host read request |
| rd_addr_i | input | ADDR_W | Read address |
| wr_req_i | input | 1 | Host write command request |
| wr_addr_i | input | ADDR_W | Write target address |
| wr_kind_i | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| bank_busy_i | input | 2 | Per-bank busy status from the command engine |
| chip_busy_i | input | 1 | Chip erase in progress |
| rd_en_o | output | 2 | Per-bank read enable |
| rd_status_o | output | 1 | Read multiplexer select: 1 selects status, 0 selects array data |
| wr_start_o | output | 2 | Per-bank write start pulse |
| wr_chip_o | output | 1 | Chip erase start pulse |
| reject_o | output | 1 | Write command refused |
| bus_oe_o | output | 1 | Drive the data bus (high impedance when 0) |

## Verification
The bench builds the arbiter with `ADDR_W` = 8 and `BANK_BIT` = 5. This keeps addresses short enough to write out by hand. The bank bit also sits below the top bit, so the bench can check that the higher address bits have no effect on bank selection. With these values the bench can reach every pairing of read and write across the two banks in one cycle, reads during chip erase, and a second write arriving right after a start.

// File: rtl/dba_pkg.sv
package dba_pkg;
  typedef enum logic [1:0] {
    WK_PROGRAM = 2'd0,
    WK_SECTOR  = 2'd1,
    WK_BLOCK   = 2'd2,
    WK_CHIP    = 2'd3
  } wr_kind_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/dba_bank_decode.sv
module dba_bank_decode #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned BANK_BIT = 19
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [1:0]        bank_oh_o
);
  always_comb begin
    bank_oh_o = addr_i[BANK_BIT] ? 2'b10 : 2'b01;
  end
endmodule

// File: rtl/dba_busy_track.sv
module dba_busy_track (
  input  logic [1:0] bank_busy_i,
  input  logic       chip_busy_i,
  input  logic [1:0] start_q_i,
  input  logic       chip_q_i,
  output logic [1:0] busy_eff_o,
  output logic       any_busy_o
);
  // an issued start counts as busy until the engine reports it
  always_comb begin
    busy_eff_o = bank_busy_i | start_q_i | {2{chip_busy_i | chip_q_i}};
    any_busy_o = |busy_eff_o;
  end
endmodule

// File: rtl/dba_write_gate.sv
module dba_write_gate
  import dba_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [1:0] wr_kind_i,
  input  logic [1:0] bank_oh_i,
  input  logic       any_busy_i,
  output logic [1:0] acc_bank_o,
  output logic       acc_chip_o,
  output logic [1:0] start_q_o,
  output logic       chip_q_o,
  output logic       reject_q_o
);
  logic accept;
  logic is_chip;

  always_comb begin
    is_chip    = wr_kind_e'(wr_kind_i) == WK_CHIP;
    accept     = wr_valid_i & ~any_busy_i;
    acc_bank_o = (accept & ~is_chip) ? bank_oh_i : 2'b00;
    acc_chip_o = accept & is_chip;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q_o  <= 2'b00;
      chip_q_o   <= 1'b0;
      reject_q_o <= 1'b0;
    end else begin
      start_q_o  <= acc_bank_o;
      chip_q_o   <= acc_chip_o;
      reject_q_o <= wr_valid_i & any_busy_i;
    end
  end

  a_r5_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_q_o));
  a_r5_no_start_on_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_q_o |-> (start_q_o == 2'b00 && !chip_q_o));
  a_r6_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_q_o || chip_q_o) |=> (start_q_o == 2'b00 && !chip_q_o));
endmodule

// File: rtl/dba_read_route.sv
module dba_read_route (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_valid_i,
  input  logic [1:0] bank_oh_i,
  input  logic [1:0] busy_eff_i,
  input  logic [1:0] acc_bank_i,
  input  logic       acc_chip_i,
  output logic [1:0] rd_en_q_o,
  output logic       status_q_o
);
  logic [1:0] en_d;
  logic [1:0] hot;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_comb begin
      en_d[b] = rd_valid_i & bank_oh_i[b];
      hot[b]  = busy_eff_i[b] | acc_bank_i[b] | acc_chip_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_q_o  <= 2'b00;
      status_q_o <= 1'b0;
    end else begin
      rd_en_q_o  <= en_d;
      status_q_o <= |(en_d & hot);
    end
  end

  a_r3_one_bank_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_en_q_o));
  a_r1_status_only_with_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q_o |-> (rd_en_q_o != 2'b00));
endmodule

// File: rtl/dual_bank_arbiter.sv
module dual_bank_arbiter #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned BANK_BIT = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [1:0]        bank_busy_i,
  input  logic              chip_busy_i,
  output logic [1:0]        rd_en_o,
  output logic              rd_status_o,
  output logic [1:0]        wr_start_o,
  output logic              wr_chip_o,
  output logic              reject_o,
  output logic              bus_oe_o
);
  logic [1:0] rd_bank, wr_bank, busy_eff, acc_bank;
  logic       any_busy, acc_chip, rd_valid, wr_valid;

  always_comb begin
    rd_valid = rd_req_i & ~ce_ni & ~oe_ni;
    wr_valid = wr_req_i & ~ce_ni;
    bus_oe_o = ~ce_ni & ~oe_ni;
  end

  dba_bank_decode #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT)) u_rd_dec (
    .addr_i(rd_addr_i), .bank_oh_o(rd_bank));
  dba_bank_decode #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT)) u_wr_dec (
    .addr_i(wr_addr_i), .bank_oh_o(wr_bank));

  dba_busy_track u_busy (
    .bank_busy_i(bank_busy_i), .chip_busy_i(chip_busy_i),
    .start_q_i(wr_start_o), .chip_q_i(wr_chip_o),
    .busy_eff_o(busy_eff), .any_busy_o(any_busy));

  dba_write_gate u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid),
    .wr_kind_i(wr_kind_i), .bank_oh_i(wr_bank), .any_busy_i(any_busy),
    .acc_bank_o(acc_bank), .acc_chip_o(acc_chip),
    .start_q_o(wr_start_o), .chip_q_o(wr_chip_o), .reject_q_o(reject_o));

  dba_read_route u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_valid_i(rd_valid),
    .bank_oh_i(rd_bank), .busy_eff_i(busy_eff),
    .acc_bank_i(acc_bank), .acc_chip_i(acc_chip),
    .rd_en_q_o(rd_en_o), .status_q_o(rd_status_o));

  a_r5_start_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_start_o || wr_chip_o) |-> $past(bank_busy_i == 2'b00 && !chip_busy_i));
  a_r2_data_needs_idle_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o != 2'b00 && !rd_status_o) |-> $past((bank_busy_i & rd_bank) == 2'b00 && !chip_busy_i));
  a_r9_ce_high_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ce_ni) |-> (rd_en_o == 2'b00 && wr_start_o == 2'b00 && !wr_chip_o && !reject_o));
  a_r7_chip_reads_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(chip_busy_i) && rd_en_o != 2'b00) |-> rd_status_o);
endmodule

// File: tb/tb_dual_bank_arbiter.sv
module tb_dual_bank_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int BANK_BIT = 5;
  localparam logic [7:0] A0 = 8'hC5;  // bank 0, high bits set
  localparam logic [7:0] A1 = 8'h21;  // bank 1

  // stim: rd rb wr wk[2] wb busy[2] cb cen oen | exp: rden[2] st ws[2] chip rej
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,2'd0,1'b0,2'b00,1'b0,1'b0,1'b0, 2'b01,1'b0,2'b00,1'b0,1'b0}, // R1
    {1'b1,1'b1,1'b0,2'd0,1'b0,2'b01,1'b0,1'b0,1'b0, 2'b10,1'b0,2'b00,1'b0,1'b0}, // R1 R3
    {1'b1,1'b0,1'b0,2'd0,1'b0,2'b01,1'b0,1'b0,1'b0, 2'b01,1'b1,2'b00,1'b0,1'b0}, // R2
    {1'b0,1'b0,1'b1,2'd0,1'b1,2'b00,1'b0,1'b0,1'b0, 2'b00,1'b0,2'b10,1'b0,1'b0}, // R4
    {1'b0,1'b0,1'b1,2'd0,1'b0,2'b10,1'b0,1'b0,1'b0, 2'b00,1'b0,2'b00,1'b0,1'b1}, // R5
    {1'b1,1'b0,1'b1,2'd1,1'b1,2'b00,1'b0,1'b0,1'b0, 2'b01,1'b0,2'b10,1'b0,1'b0}, // R8
    {1'b1,1'b1,1'b1,2'd2,1'b1,2'b00,1'b0,1'b0,1'b0, 2'b10,1'b1,2'b10,1'b0,1'b0}, // R8
    {1'b0,1'b0,1'b1,2'd2,1'b0,2'b00,1'b0,1'b0,1'b0, 2'b00,1'b0,2'b01,1'b0,1'b0}, // R4
    {1'b0,1'b0,1'b1,2'd3,1'b1,2'b00,1'b0,1'b0,1'b0, 2'b00,1'b0,2'b00,1'b1,1'b0}, // R4
    {1'b1,1'b1,1'b0,2'd0,1'b0,2'b00,1'b1,1'b0,1'b0, 2'b10,1'b1,2'b00,1'b0,1'b0}, // R7
    {1'b1,1'b0,1'b1,2'd2,1'b0,2'b00,1'b1,1'b0,1'b0, 2'b01,1'b1,2'b00,1'b0,1'b1}, // R7 R5
    {1'b1,1'b0,1'b0,2'd0,1'b0,2'b00,1'b0,1'b1,1'b0, 2'b00,1'b0,2'b00,1'b0,1'b0}, // R9
    {1'b1,1'b1,1'b1,2'd0,1'b0,2'b00,1'b0,1'b0,1'b1, 2'b00,1'b0,2'b01,1'b0,1'b0}, // R9
    {1'b0,1'b0,1'b1,2'd0,1'b1,2'b11,1'b0,1'b1,1'b0, 2'b00,1'b0,2'b00,1'b0,1'b0}, // R9
    {1'b1,1'b0,1'b1,2'd3,1'b0,2'b00,1'b0,1'b0,1'b0, 2'b01,1'b1,2'b00,1'b1,1'b0}  // R8
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n, oe_n, rd_req, wr_req, chip_busy;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [1:0] wr_kind, bank_busy, rd_en, wr_start;
  logic rd_status, wr_chip, reject, bus_oe;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_arbiter #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .wr_req_i(wr_req),
    .wr_addr_i(wr_addr), .wr_kind_i(wr_kind), .bank_busy_i(bank_busy),
    .chip_busy_i(chip_busy), .rd_en_o(rd_en), .rd_status_o(rd_status),
    .wr_start_o(wr_start), .wr_chip_o(wr_chip), .reject_o(reject),
    .bus_oe_o(bus_oe));

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {rd_en, rd_status, wr_start, wr_chip, reject};
  endfunction

  task automatic idle();
    rd_req = 0; wr_req = 0; wr_kind = 0; bank_busy = 0; chip_busy = 0;
    ce_n = 0; oe_n = 0; rd_addr = A0; wr_addr = A0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rd_req = 1; wr_req = 1; wr_kind = 0;
    repeat (3) @(negedge clk);
    check("R11", outs(), 7'b0);
    idle();
    rst_n = 1;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      rd_req = v[17]; rd_addr = v[16] ? A1 : A0;
      wr_req = v[15]; wr_kind = v[14:13]; wr_addr = v[12] ? A1 : A0;
      bank_busy = v[11:10]; chip_busy = v[9]; ce_n = v[8]; oe_n = v[7];
      step();
      check($sformatf("R1..vector %0d", i), outs(), v[6:0]);
      idle();
      step();
    end

    // R10 combinational bus enable
    ce_n = 0; oe_n = 0; #1; total++; if (bus_oe !== 1'b1) begin bad++; $display("FAIL R10 act=%b exp=1", bus_oe); end
    oe_n = 1; #1; total++; if (bus_oe !== 1'b0) begin bad++; $display("FAIL R10 act=%b exp=0", bus_oe); end
    ce_n = 1; oe_n = 0; #1; total++; if (bus_oe !== 1'b0) begin bad++; $display("FAIL R10 act=%b exp=0", bus_oe); end
    idle();
    step();

    // R6 back-to-back writes
    wr_req = 1; wr_kind = 0; wr_addr = A0;
    step();
    check("R6 first", outs(), 7'b00_0_01_0_0);
    wr_addr = A1;
    step();
    check("R6 second", outs(), 7'b00_0_00_0_1);
    idle();
    step();

    // R7 read during chip start pulse
    wr_req = 1; wr_kind = 3;
    step();
    check("R7 chip start", outs(), 7'b00_0_00_1_0);
    wr_req = 0; rd_req = 1; rd_addr = A1;
    step();
    check("R7 read in chip pulse", outs(), 7'b10_1_00_0_0);
    idle();
    step();

    // R3 upper address bits ignored
    rd_req = 1; rd_addr = 8'hDF;
    step();
    check("R3 high bits", outs(), 7'b01_0_00_0_0);
    rd_addr = 8'h20;
    step();
    check("R3 bank bit", outs(), 7'b10_0_00_0_0);
    idle();

    // R11 async reset clears outputs
    wr_req = 1;
    step();
    #1 rst_n = 0; #1;
    check("R11 async", outs(), 7'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule